// File: doc/BRIEF.md
# BCD Calendar Timekeeping Register File

This block is the counting core of a real-time clock. It holds the time of day, the day of the week, the calendar date and a century count as eight packed-BCD registers. Each register keeps the tens digit in bits 7:4 and the units digit in bits 3:0. An external prescaler supplies a one-cycle pulse once per second, and each accepted pulse advances the time by one second. The carry passes through every calendar field, and the month lengths follow the leap-year rule.

Software reaches the block through a small synchronous register port: an address, a write strobe, write data, and read data that follows the address combinationally. A hold bit in the control register stops all counting. Time fields can only be written while the hold bit is set. When software clears the bit again, the values it wrote become the running time.

Top module: `bcd_rtc_regs`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, weekday 01, date 01, month 01, year 00, century 00, and the hold bit reads 0.
- R2: An accepted tick adds one second. Seconds go from 59 to 00 and carry into minutes.
- R3: Minutes go from 59 to 00 and carry into hours. Hours count in 24-hour form and go from 23 to 00, which advances the weekday and the date.
- R4: The weekday counts 01 to 07 and goes from 07 back to 01.
- R5: The date returns to 01 after the 30th of April, June, September and November, and after the 31st of the other long months. The month advances at the same time.
- R6: February ends on day 29 in a leap year and on day 28 otherwise. A year other than 00 is a leap year when it is divisible by 4. Year 00 is a leap year when the century is divisible by 4.
- R7: Month 12 goes to 01 and increments the year. Year 99 goes to 00 and increments the century, which itself wraps from 99 to 00.
- R8: While the hold bit is 1, no field changes on a tick. Ticks that arrive during hold are discarded, not queued.
- R9: A write to a time field while the hold bit is 0 has no effect.
- R10: After the hold bit is cleared, counting continues from the values written during hold.
- R11: Address map with the default parameters: 0 is the control register (bit 0 = hold; reads return the hold bit in bit 0 and zeros above it). Addresses 1 to 8 are seconds, minutes, hours, weekday, date, month, year and century. Any other address reads 0x00. A write to the control register takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |

## Verification
The bench builds the block with its default parameters: a 4-bit address, the control register at 0 and the time fields starting at 1. With these values the whole map, including one unmapped address, is visible through the port. Because software can load any base time during hold, a single tick from a chosen instant reaches every rollover without running through long stretches of seconds. Those instants cover the end of a year and of a century, the month lengths, February in the years 2000, 2023, 2024 and 2100, and BCD tens steps such as month 09 to 10 and hour 09 to 10.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD = 8;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_CENT = 7;

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] b);
    if (b[3:0] >= 4'd9) return {b[7:4] + 4'd1, 4'h0};
    return {b[7:4], b[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr, input logic [7:0] cen);
    logic [6:0] v;
    v = (yr == 8'h00) ? bcd_to_bin(cen) : bcd_to_bin(yr);
    return (v[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] reset_value(input int idx);
    if (idx == F_DOW || idx == F_DATE || idx == F_MON) return 8'h01;
    return 8'h00;
  endfunction
endpackage

// File: rtl/rtc_next_time.sv
module rtc_next_time
  import rtc_pkg::*;
(
  input  logic [NFIELD-1:0][7:0] cur,
  output logic [NFIELD-1:0][7:0] nxt,
  output logic [NFIELD-1:0]      roll
);
  logic leap;
  logic [7:0] mon_end;

  assign leap    = is_leap(cur[F_YEAR], cur[F_CENT]);
  assign mon_end = last_day(cur[F_MON], leap);

  // each roll bit: this field wraps on the current second
  assign roll[F_SEC]  = cur[F_SEC] >= 8'h59;
  assign roll[F_MIN]  = roll[F_SEC]  && (cur[F_MIN]  >= 8'h59);
  assign roll[F_HOUR] = roll[F_MIN]  && (cur[F_HOUR] >= 8'h23);
  assign roll[F_DOW]  = roll[F_HOUR] && (cur[F_DOW]  >= 8'h07);
  assign roll[F_DATE] = roll[F_HOUR] && (cur[F_DATE] >= mon_end);
  assign roll[F_MON]  = roll[F_DATE] && (cur[F_MON]  >= 8'h12);
  assign roll[F_YEAR] = roll[F_MON]  && (cur[F_YEAR] >= 8'h99);
  assign roll[F_CENT] = roll[F_YEAR] && (cur[F_CENT] >= 8'h99);

  logic [NFIELD-1:0] step;
  assign step[F_SEC]  = 1'b1;
  assign step[F_MIN]  = roll[F_SEC];
  assign step[F_HOUR] = roll[F_MIN];
  assign step[F_DOW]  = roll[F_HOUR];
  assign step[F_DATE] = roll[F_HOUR];
  assign step[F_MON]  = roll[F_DATE];
  assign step[F_YEAR] = roll[F_MON];
  assign step[F_CENT] = roll[F_YEAR];

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    localparam logic [7:0] LOW = reset_value(i);
    assign nxt[i] = !step[i] ? cur[i] : (roll[i] ? LOW : bcd_inc(cur[i]));
  end
endmodule

// File: rtl/rtc_bus_port.sv
module rtc_bus_port
  import rtc_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CTRL_ADDR  = 0,
  parameter int FIELD_BASE = 1
) (
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   hold,
  input  logic [NFIELD-1:0][7:0] fld,
  output logic                   ctrl_wr,
  output logic [NFIELD-1:0]      fld_wr,
  output logic [7:0]             rd_data
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  assign ctrl_wr = wr_en && (addr == CTRL_A);

  for (genvar i = 0; i < NFIELD; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] FA = ADDR_W'(FIELD_BASE + i);
    assign fld_wr[i] = wr_en && hold && (addr == FA);
  end

  always_comb begin
    rd_data = 8'h00;
    if (addr == CTRL_A) rd_data = {7'b0, hold};
    for (int i = 0; i < NFIELD; i++)
      if (addr == ADDR_W'(FIELD_BASE + i)) rd_data = fld[i];
  end
endmodule

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs
  import rtc_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CTRL_ADDR  = 0,
  parameter int FIELD_BASE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data
);
  logic                   hold_q;
  logic                   advance;
  logic                   ctrl_wr;
  logic [NFIELD-1:0]      fld_wr;
  logic [NFIELD-1:0]      roll;
  logic [NFIELD-1:0][7:0] fld_q;
  logic [NFIELD-1:0][7:0] fld_nxt;

  assign advance = tick && !hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       hold_q <= 1'b0;
    else if (ctrl_wr) hold_q <= wr_data[0];
  end

  rtc_bus_port #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .FIELD_BASE(FIELD_BASE)
  ) u_port (
    .wr_en(wr_en), .addr(addr), .hold(hold_q), .fld(fld_q),
    .ctrl_wr(ctrl_wr), .fld_wr(fld_wr), .rd_data(rd_data)
  );

  rtc_next_time u_next (.cur(fld_q), .nxt(fld_nxt), .roll(roll));

  for (genvar i = 0; i < NFIELD; i++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)         q <= reset_value(i);
      else if (fld_wr[i]) q <= wr_data;
      else if (advance)   q <= fld_nxt[i];
    end
    assign fld_q[i] = q;
  end
endmodule

// File: rtl/rtc_regs_chk.sv
module rtc_regs_chk
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [ADDR_W-1:0]      addr,
  input logic                   hold_q,
  input logic                   advance,
  input logic [NFIELD-1:0]      roll,
  input logic [NFIELD-1:0][7:0] fld_q
);
  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && fld_q[F_SEC] == 8'h59) |=> (fld_q[F_SEC] == 8'h00));

  p_hour_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && fld_q[F_HOUR] <= 8'h23) |=> (fld_q[F_HOUR] <= 8'h23));

  p_dow_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && roll[F_HOUR] && fld_q[F_DOW] == 8'h07) |=> (fld_q[F_DOW] == 8'h01));

  p_month_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && fld_q[F_MON] >= 8'h01 && fld_q[F_MON] <= 8'h12)
      |=> (fld_q[F_MON] >= 8'h01 && fld_q[F_MON] <= 8'h12));

  p_century_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && roll[F_YEAR]) |=> (fld_q[F_CENT] != $past(fld_q[F_CENT])));

  p_hold_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !wr_en) |=> $stable(fld_q));

  p_ignored_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hold_q && !advance && addr != ADDR_W'(CTRL_ADDR)) |=> $stable(fld_q));
endmodule

bind bcd_rtc_regs rtc_regs_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .hold_q(hold_q),
  .advance(advance), .roll(roll), .fld_q(fld_q)
);

// File: tb/sim_bcd_rtc_regs.sv
module sim_bcd_rtc_regs;
  localparam int AW = 4;
  localparam int NV = 13;
  // each entry: {start time, expected after one tick}; bytes sec,min,hour,dow,date,mon,year,cent
  localparam logic [127:0] VEC [NV] = '{
    {64'h59592307_31129920, 64'h00000001_01010021},
    {64'h56341203_15062420, 64'h57341203_15062420},
    {64'h59591002_30042320, 64'h00001102_30042320},
    {64'h59592302_30042320, 64'h00000003_01052320},
    {64'h59592301_28022320, 64'h00000002_01032320},
    {64'h59592301_28022420, 64'h00000002_29022420},
    {64'h59592304_29022420, 64'h00000005_01032420},
    {64'h59592305_31012520, 64'h00000006_01022520},
    {64'h59592301_28020020, 64'h00000002_29020020},
    {64'h59592301_28020021, 64'h00000002_01030021},
    {64'h59592306_30092520, 64'h00000007_01102520},
    {64'h59590904_10101020, 64'h00001004_10101020},
    {64'h59592307_31129999, 64'h00000001_01010000}
  };

  function automatic string vtag(input int i);
    case (i)
      0:  return "R4 R7 year end";
      1:  return "R2 plain second";
      2:  return "R3 hour carry";
      3:  return "R5 30-day month";
      4:  return "R6 Feb non-leap";
      5:  return "R6 Feb leap 28";
      6:  return "R6 Feb leap 29";
      7:  return "R5 31-day month";
      8:  return "R6 year 00 leap century";
      9:  return "R6 year 00 non-leap century";
      10: return "R5 month 09 to 10";
      11: return "R3 hour 09 to 10";
      default: return "R7 century wrap";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bcd_rtc_regs #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = AW'(a); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); addr = AW'(a); #0.5; d = rd_data;
  endtask

  task automatic pulse;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic load(input logic [63:0] t);
    wr(0, 8'h01);
    for (int i = 0; i < 8; i++) wr(1 + i, t[63 - 8*i -: 8]);
    wr(0, 8'h00);
  endtask

  task automatic check_all(input string tag, input logic [63:0] exp);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(1 + i, v);
      check(tag, v, exp[63 - 8*i -: 8]);
    end
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check_all("R1 reset fields", 64'h00000001_01010000);
    rd(0, v); check("R1 hold after reset", v, 8'h00);

    // R2..R7 via table
    for (int k = 0; k < NV; k++) begin
      load(VEC[k][127:64]);
      pulse();
      check_all(vtag(k), VEC[k][63:0]);
    end

    // R11: control readback and unmapped address
    wr(0, 8'h01);
    rd(0, v); check("R11 hold reads back", v, 8'h01);
    rd(15, v); check("R11 unmapped reads zero", v, 8'h00);

    // R8: ticks during hold are frozen and discarded
    load(64'h10203004_15072520);
    wr(0, 8'h01);
    repeat (3) pulse();
    check_all("R8 frozen during hold", 64'h10203004_15072520);
    wr(0, 8'h00);
    pulse();
    rd(1, v); check("R8 held ticks discarded", v, 8'h11);

    // R9: field write ignored with hold clear
    wr(1, 8'h33);
    rd(1, v); check("R9 write without hold ignored", v, 8'h11);
    wr(3, 8'h22);
    rd(3, v); check("R9 hour unchanged", v, 8'h30);

    // R10: resume from written base time
    load(64'h58000001_01010000);
    pulse(); pulse();
    check_all("R10 resume from base", 64'h00010001_01010000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule